// File: doc/BRIEF.md
# Evicted-Address Reuse Predictor

This block tells a cache whether a block that has just missed is likely to be used again. It keeps a probabilistic record of the addresses the cache has recently thrown out. Each victim address goes into a bit-array membership filter. When the same address misses again soon after its eviction, that is taken as a sign that the block was evicted too early. The cache uses the one-bit answer to choose between a high-priority and a low-priority insertion position.

The filter is wiped as a whole. This happens when a programmable number of insertions have been recorded, or when an external clear input asks for it. No entry ages on its own. Because of the bounded wipe, a working set that is larger than the cache cannot fill the filter. Only the part of it that was evicted since the last wipe is reported as high reuse.

Top module: `evict_reuse_pred`

## Requirements
- R1: When `evict_valid_i` is high and no clear takes effect in that cycle, the bits selected by both hash indices of `evict_addr_i` are set from the next cycle on.
- R2: With a filter of M = 2^W bits, hash index A is the XOR of the address bits whose position modulo W equals each index bit. Hash index B is the same fold applied to the bit-reversed address. So addresses that differ only in bits 5 and 15 alias under both hashes.
- R3: `pred_valid_o` is `miss_valid_i` delayed by one cycle. `pred_reuse_o` is 1 exactly when `miss_valid_i` was high and both filter bits of `miss_addr_i` were set. It is 0 whenever `pred_valid_o` is 0.
- R4: An address inserted since the most recent wipe is always predicted as high reuse (no false negatives).
- R5: A missed address whose two bits are not both set is predicted as low reuse.
- R6: A lookup in the same cycle as an insert or a clear sees the filter as it was before that cycle.
- R7: Each recorded insert increments the insert count. The insert that would bring the count to `limit_i` instead clears the whole filter and the count, and its own bits are not kept.
- R8: `clear_i` clears the whole filter and the count in the next cycle. It overrides a same-cycle insert, which is neither recorded nor counted.
- R9: While `rst_ni` is low, the filter, the count and both outputs are cleared.
- R10: Set bits stay set for any number of idle cycles until a wipe; no per-entry aging exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evict_valid_i | input | 1 | Victim address strobe |
| evict_addr_i | input | 32 | Victim block address |
| miss_valid_i | input | 1 | Miss lookup strobe |
| miss_addr_i | input | 32 | Missed block address |
| clear_i | input | 1 | Immediate full wipe request |
| limit_i | input | 16 | Number of inserts that triggers a wipe |
| pred_valid_o | output | 1 | Prediction valid, one cycle after the strobe |
| pred_reuse_o | output | 1 | 1 = high reuse, 0 = low reuse |

## Verification
An insert and a lookup can land in the same cycle, and either can also meet a wipe, whether from the limit or from `clear_i`. The bench provokes this in two ways. Directed steps evict and miss the same address together, including on the insert that reaches the limit. Random traffic over a small address pool produces many more such collisions. Each step is judged against a bench-side filter model. The model computes the prediction from its state before it applies that cycle's insert or wipe.

// File: rtl/evf_pkg.sv
package evf_pkg;
  parameter int unsigned ADDR_W    = 32;
  parameter int unsigned FILT_BITS = 1024;
  parameter int unsigned CNT_W     = 16;
  parameter int unsigned NHASH     = 2;
endpackage

// File: rtl/evf_hash.sv
module evf_hash #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned VARIANT = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned NSLICE = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NSLICE * IDX_W;

  logic [ADDR_W-1:0] src;
  logic [PAD_W-1:0]  padded;

  generate
    if (VARIANT == 0) begin : g_plain
      assign src = addr_i;
    end else begin : g_rev
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign src[i] = addr_i[ADDR_W-1-i];
      end
    end
  endgenerate

  assign padded = PAD_W'(src);

  always_comb begin
    idx_o = '0;
    for (int s = 0; s < NSLICE; s++) begin
      idx_o ^= padded[s*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/evf_bitarray.sv
module evf_bitarray #(
  parameter int unsigned FILT_BITS = 1024,
  parameter int unsigned NHASH     = 2,
  localparam int unsigned IDX_W    = $clog2(FILT_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i [NHASH],
  input  logic             wipe_i,
  input  logic [IDX_W-1:0] qry_idx_i [NHASH],
  output logic             hit_o
);
  logic [FILT_BITS-1:0] bits_q;
  logic [FILT_BITS-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    for (int k = 0; k < NHASH; k++) set_mask[set_idx_i[k]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bits_q <= '0;
    else if (wipe_i)   bits_q <= '0;
    else if (set_en_i) bits_q <= bits_q | set_mask;
  end

  // all k bits must be set
  always_comb begin
    hit_o = 1'b1;
    for (int k = 0; k < NHASH; k++) hit_o &= bits_q[qry_idx_i[k]];
  end

  generate
    for (genvar k = 0; k < NHASH; k++) begin : g_chk
      assert_insert_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i && !wipe_i |=> bits_q[$past(set_idx_i[k])]);
    end
  endgenerate

  assert_wipe_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> bits_q == '0);

  assert_no_decay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wipe_i |=> (($past(bits_q) & ~bits_q) == '0));
endmodule

// File: rtl/evf_clear_ctl.sv
module evf_clear_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             set_en_o,
  output logic             wipe_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;
  logic             ins_fire;
  logic             at_limit;

  assign count_inc = count_q + CNT_W'(1);
  assign ins_fire  = ins_i & ~clr_i;
  assign at_limit  = ins_fire & (count_inc == limit_i);
  assign wipe_o    = clr_i | at_limit;
  assign set_en_o  = ins_fire & ~at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (wipe_o)   count_q <= '0;
    else if (ins_fire) count_q <= count_inc;
  end

  assert_clear_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> wipe_o && !set_en_o);

  assert_clear_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_q == '0);

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_o |=> count_q == $past(count_q) + CNT_W'(1));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_i && !clr_i |=> $stable(count_q));
endmodule

// File: rtl/evict_reuse_pred.sv
module evict_reuse_pred #(
  parameter int unsigned ADDR_W    = evf_pkg::ADDR_W,
  parameter int unsigned FILT_BITS = evf_pkg::FILT_BITS,
  parameter int unsigned CNT_W     = evf_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic              pred_valid_o,
  output logic              pred_reuse_o
);
  localparam int unsigned NHASH = evf_pkg::NHASH;
  localparam int unsigned IDX_W = $clog2(FILT_BITS);

  logic [IDX_W-1:0] ev_idx [NHASH];
  logic [IDX_W-1:0] ms_idx [NHASH];
  logic set_en, wipe, hit;
  logic pred_valid_q, pred_reuse_q;

  generate
    for (genvar k = 0; k < NHASH; k++) begin : g_hash
      evf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(k)) u_ev_hash (
        .addr_i(evict_addr_i), .idx_o(ev_idx[k]));
      evf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(k)) u_ms_hash (
        .addr_i(miss_addr_i), .idx_o(ms_idx[k]));
    end
  endgenerate

  evf_clear_ctl #(.CNT_W(CNT_W)) u_clear_ctl (
    .clk_i, .rst_ni,
    .ins_i(evict_valid_i), .clr_i(clear_i), .limit_i,
    .set_en_o(set_en), .wipe_o(wipe));

  evf_bitarray #(.FILT_BITS(FILT_BITS), .NHASH(NHASH)) u_bitarray (
    .clk_i, .rst_ni,
    .set_en_i(set_en), .set_idx_i(ev_idx), .wipe_i(wipe),
    .qry_idx_i(ms_idx), .hit_o(hit));

  // lookup reads pre-update array state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q <= 1'b0;
      pred_reuse_q <= 1'b0;
    end else begin
      pred_valid_q <= miss_valid_i;
      pred_reuse_q <= miss_valid_i & hit;
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_reuse_o = pred_reuse_q;

  assert_pred_timing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> pred_valid_o);

  assert_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> !pred_reuse_o);

  assert_pre_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && hit |=> pred_reuse_o);
endmodule

// File: tb/evict_reuse_pred_test.sv
`timescale 1ns/1ps
module evict_reuse_pred_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evict_valid_i = 1'b0;
  logic [31:0] evict_addr_i = '0;
  logic        miss_valid_i = 1'b0;
  logic [31:0] miss_addr_i = '0;
  logic        clear_i = 1'b0;
  logic [15:0] limit_i = 16'd256;
  logic        pred_valid_o, pred_reuse_o;

  int total = 0;
  int bad = 0;
  bit mdl [1024];
  int unsigned mcnt = 0;
  logic [31:0] pool [40];

  always #2 clk_i = ~clk_i;

  evict_reuse_pred uut (.*);

  function automatic int fold_a(logic [31:0] a);
    int h = 0;
    for (int i = 0; i < 32; i++) if (a[i]) h ^= (1 << (i % 10));
    return h;
  endfunction

  function automatic int fold_b(logic [31:0] a);
    int h = 0;
    for (int i = 0; i < 32; i++) if (a[31-i]) h ^= (1 << (i % 10));
    return h;
  endfunction

  function automatic bit mdl_hit(logic [31:0] a);
    return mdl[fold_a(a)] && mdl[fold_b(a)];
  endfunction

  function automatic void mdl_wipe();
    for (int i = 0; i < 1024; i++) mdl[i] = 1'b0;
    mcnt = 0;
  endfunction

  function automatic void mdl_update(bit ev, logic [31:0] ea, bit clr);
    if (clr) mdl_wipe();
    else if (ev) begin
      if (16'(mcnt + 1) == limit_i) mdl_wipe();
      else begin
        mdl[fold_a(ea)] = 1'b1;
        mdl[fold_b(ea)] = 1'b1;
        mcnt++;
      end
    end
  endfunction

  task automatic step(bit ev, logic [31:0] ea, bit mv, logic [31:0] ma, bit clr, string tag);
    bit exp_r;
    evict_valid_i = ev; evict_addr_i = ea;
    miss_valid_i = mv;  miss_addr_i = ma;
    clear_i = clr;
    exp_r = mv && mdl_hit(ma);
    mdl_update(ev, ea, clr);
    @(negedge clk_i);
    total++;
    if (pred_valid_o !== mv || pred_reuse_o !== exp_r) begin
      bad++;
      $display("FAIL %s: valid=%0b reuse=%0b expected valid=%0b reuse=%0b",
               tag, pred_valid_o, pred_reuse_o, mv, exp_r);
    end
    evict_valid_i = 1'b0; miss_valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic expect_bit(bit act, bit exp_v, string tag);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b", tag, act, exp_v);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c;
    void'($urandom(32'd1234));
    mdl_wipe();
    repeat (3) @(negedge clk_i);
    expect_bit(pred_valid_o, 1'b0, "R9 reset valid");
    expect_bit(pred_reuse_o, 1'b0, "R9 reset reuse");
    rst_ni = 1'b1;
    @(negedge clk_i);

    a = 32'h1234_5678; b = 32'hCAFE_0040; c = 32'h0BAD_F00D;
    step(0, 0, 1, a, 0, "R5 empty filter miss");
    step(1, a, 0, 0, 0, "R1 insert");
    step(0, 0, 1, a, 0, "R4 evicted address hits");
    step(0, 0, 1, b, 0, "R5 unknown address low");
    step(0, 0, 1, a ^ 32'h0000_8020, 0, "R2 alias via bits 5 and 15");
    step(0, 0, 1, a ^ 32'h0000_0020, 0, "R2 single-bit change");
    // R6: same-cycle insert and query
    step(1, b, 1, b, 0, "R6 query before insert");
    step(0, 0, 1, b, 0, "R6 insert visible next cycle");
    // R10: idle persistence
    repeat (60) step(0, 0, 0, 0, 0, "R3 idle valid low");
    step(0, 0, 1, a, 0, "R10 bit persists");
    // R8: clear with same-cycle insert and query
    step(1, c, 1, a, 1, "R8 query before clear");
    step(0, 0, 1, a, 0, "R8 cleared address low");
    step(0, 0, 1, c, 0, "R8 insert overridden");
    // R7: limit 3
    limit_i = 16'd3;
    step(1, a, 0, 0, 0, "R7 insert 1");
    step(1, b, 0, 0, 0, "R7 insert 2");
    step(0, 0, 1, a, 0, "R7 before limit");
    step(1, c, 1, c, 0, "R7 limit insert same-cycle");
    step(0, 0, 1, a, 0, "R7 wiped at limit");
    step(0, 0, 1, c, 0, "R7 limit insert dropped");
    step(1, c, 0, 0, 0, "R7 count restarted");
    step(0, 0, 1, c, 0, "R7 insert after wipe");
    // R9: reset mid-run
    rst_ni = 1'b0;
    mdl_wipe();
    @(negedge clk_i);
    expect_bit(pred_valid_o, 1'b0, "R9 reset in run");
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 0, 1, c, 0, "R9 filter empty after reset");

    // random traffic over a small pool
    for (int i = 0; i < 40; i++) pool[i] = $urandom;
    for (int ph = 0; ph < 2; ph++) begin
      limit_i = (ph == 0) ? 16'd256 : 16'd7;
      for (int n = 0; n < 4000; n++) begin
        bit ev, mv, clr;
        ev  = ($urandom % 2) == 0;
        mv  = ($urandom % 5) < 3;
        clr = ($urandom % 200) == 0;
        step(ev, pool[$urandom % 40], mv, pool[$urandom % 40], clr, "R3 random lookup");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule